// File: doc/BRIEF.md
# ECC-Protected FIFO with Initialisation Window

This block is a 1024-word first-in first-out store whose every location holds a 32-bit word plus seven check bits of a single-error-correct, double-error-detect Hamming code. Producers push words and consumers pop them through a plain streaming interface. A second, address-mapped path lets software write and read storage locations directly. It is used to zero the whole store before error checking is switched on, because locations that were never written carry random check bits.

Checking is switched on at run time by a level input. While it is on, a read with one flipped bit is corrected and a read with two flipped bits is passed on as stored. Each case raises a sticky flag that belongs to the read path that saw it: the pop path or the window path. Flags are cleared by writing ones. A pointer reset empties the queue without touching the stored words. A fault-injection mask can be XORed into the codeword on any write, so that the error paths can be exercised.

Top module: `ecc_fifo`

## Requirements
- R1: After a synchronous active-low reset: level is 0, empty is 1, full is 0, and pop_valid, win_rvalid, ovf, udf and all of err_flags are 0.
- R2: Words leave in the order they were pushed. A pop accepted in one cycle gives pop_valid=1 and the word on pop_data in the following cycle. Push and pop may both be accepted in the same cycle.
- R3: full rises when level reaches 1024. A push while full is dropped, level stays at 1024, and the sticky flag ovf is set.
- R4: A pop while empty is dropped, no pop_valid follows, and the sticky flag udf is set.
- R5: Window word addresses 0x200 to 0x5FF map to storage locations 0 to 1023 (location = address − 0x200). A write outside that range is dropped. A window read inside the range gives win_rvalid=1 and the word in the next cycle, and a read outside it gives no win_rvalid. A push in the same cycle wins over a window write.
- R6: ptr_clr empties the queue (level 0, empty 1) and clears ovf and udf. It drops any push or pop in that cycle and leaves the stored words unchanged.
- R7: Every write stores a 39-bit codeword in Hamming position order. Bit 0 is overall parity, bits 1, 2, 4, 8, 16 and 32 are check bits, and data bits 0, 1, 2, 3 sit at codeword bits 3, 5, 6, 7, with the rest following in ascending order. Check bits are generated whether checking is on or off, and inj_flip is XORed into the codeword as it is written.
- R8: While ecc_en is 0, both read paths return the stored data bits unchanged, and err_flags does not change except by clearing.
- R9: While ecc_en is 1, a read with one flipped bit returns corrected data. In the cycle after the data appears, it sets the single-error flag of its path: err_flags[0] for pop, err_flags[2] for window.
- R10: While ecc_en is 1, a read with two flipped bits returns the stored data bits uncorrected and sets the double-error flag of its path: err_flags[1] for pop, err_flags[3] for window.
- R11: Writing a 1 on a bit of err_clr clears that flag in the next cycle. A flag being set in the same cycle as its clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push | input | 1 | Push request |
| push_data | input | 32 | Word to push |
| full | output | 1 | Queue holds 1024 words |
| pop | input | 1 | Pop request |
| pop_data | output | 32 | Popped word, valid with pop_valid |
| pop_valid | output | 1 | pop_data carries a word this cycle |
| empty | output | 1 | Queue holds no words |
| level | output | 11 | Number of words held |
| ovf | output | 1 | Sticky: a push arrived while full |
| udf | output | 1 | Sticky: a pop arrived while empty |
| ptr_clr | input | 1 | Pointer and counter reset |
| win_we | input | 1 | Window write strobe |
| win_re | input | 1 | Window read strobe |
| win_addr | input | 11 | Window word address |
| win_wdata | input | 32 | Window write word |
| win_rdata | output | 32 | Window read word, valid with win_rvalid |
| win_rvalid | output | 1 | win_rdata carries a word this cycle |
| ecc_en | input | 1 | Checking and correction enable |
| err_clr | input | 4 | Write-one-to-clear strobes for err_flags |
| err_flags | output | 4 | Sticky error flags: [0] pop single, [1] pop double, [2] window single, [3] window double |
| inj_flip | input | 39 | Mask XORed into the codeword on writes |

## Verification
The flag assertions assume that the read side stays quiet whenever ecc_en changes, and that locations are zeroed before checking is turned on. The stimulus initialises every location through the window before any check runs. It moves ecc_en only while no read is in flight. It applies inj_flip with at most two bits set, and only at locations that are read once before being rewritten. The random phase keeps inj_flip at zero and ptr_clr low, so any flag that rises there is a real fault.

// File: rtl/ecc_fifo_pkg.sv
// Package ecc_fifo_pkg
// Shared widths and the (39,32) Hamming SECDED encode/decode functions.
// Assumes codeword bit 0 is overall parity and bits at powers of two are checks.
package ecc_fifo_pkg;
    localparam int DATA_W = 32;
    localparam int CW_W   = 39;
    localparam int SYN_W  = 6;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sbe;
        logic              dbe;
    } dec_t;

    // Place data bits at non-power-of-two positions, then fill checks and parity.
    function automatic logic [CW_W-1:0] secded_enc(input logic [DATA_W-1:0] d);
        logic [CW_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                c[p] = d[k];
                k++;
            end
        end
        for (int i = 0; i < SYN_W; i++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CW_W; p++) begin
                if (((p >> i) & 1) == 1) x = x ^ c[p];
            end
            c[1 << i] = x;
        end
        c[0] = ^c[CW_W-1:1];
        return c;
    endfunction

    // Compute syndrome and overall parity, fix a single error, report severity.
    function automatic dec_t secded_dec(input logic [CW_W-1:0] c);
        dec_t r;
        logic [SYN_W-1:0] syn;
        logic odd;
        logic [CW_W-1:0] f;
        int k;
        syn = '0;
        for (int p = 1; p < CW_W; p++) begin
            if (c[p]) syn = syn ^ SYN_W'(p);
        end
        odd = ^c;
        f = c;
        r.sbe = 1'b0;
        r.dbe = 1'b0;
        if (odd && (int'(syn) < CW_W)) begin
            r.sbe = 1'b1;
            if (syn != '0) f[syn] = ~f[syn];
        end else if (odd || (syn != '0)) begin
            r.dbe = 1'b1;
        end
        r.data = '0;
        k = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                r.data[k] = f[p];
                k++;
            end
        end
        return r;
    endfunction

    // Pull the data bits out of a codeword without any correction.
    function automatic logic [DATA_W-1:0] raw_data(input logic [CW_W-1:0] c);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p < CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = c[p];
                k++;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/ecc_fifo_ptrs.sv
// Module ecc_fifo_ptrs
// Read/write pointers, occupancy counter and sticky overflow/underflow flags.
// Assumes DEPTH is a power of two so pointers wrap naturally.
module ecc_fifo_ptrs #(
    parameter int DEPTH  = 1024,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int LVL_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              clr,
    output logic              do_push,
    output logic              do_pop,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              ovf,
    output logic              udf
);
    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;

    // Advance pointers and count on accepted transfers; clear on reset or ptr clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + ADDR_W'(1);
            if (do_pop)  rd_ptr <= rd_ptr + ADDR_W'(1);
            case ({do_push, do_pop})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    // Latch misuse of the streaming side until reset or ptr clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ovf <= 1'b0;
            udf <= 1'b0;
        end else begin
            if (push && full)  ovf <= 1'b1;
            if (pop && empty)  udf <= 1'b1;
        end
    end
endmodule

// File: rtl/ecc_fifo_ram.sv
// Module ecc_fifo_ram
// One write port and two registered read ports (A: pop, B: window) over codewords.
// Assumes the stored words are not reset; only the valid strobes are.
module ecc_fifo_ram #(
    parameter int DEPTH  = 1024,
    parameter int WIDTH  = 39,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              re_a,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic              re_b,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [WIDTH-1:0]  rdata_a,
    output logic [WIDTH-1:0]  rdata_b,
    output logic              rvalid_a,
    output logic              rvalid_b
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store a codeword on the write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Capture read words on each port when requested.
    always_ff @(posedge clk) begin
        if (re_a) rdata_a <= mem[raddr_a];
        if (re_b) rdata_b <= mem[raddr_b];
    end

    // Mark the cycle in which each read word is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_a <= 1'b0;
            rvalid_b <= 1'b0;
        end else begin
            rvalid_a <= re_a;
            rvalid_b <= re_b;
        end
    end
endmodule

// File: rtl/ecc_fifo_dec.sv
// Module ecc_fifo_dec
// Checks one read word: corrects/flags when enabled, passes raw bits when not.
// Assumes flags are only meaningful while valid is high.
module ecc_fifo_dec
    import ecc_fifo_pkg::*;
(
    input  logic              valid,
    input  logic              ecc_en,
    input  logic [CW_W-1:0]   cw,
    output logic [DATA_W-1:0] data,
    output logic              sbe,
    output logic              dbe
);
    dec_t res;

    // Pick corrected or raw data and qualify the error strobes.
    always_comb begin
        res  = secded_dec(cw);
        data = ecc_en ? res.data : raw_data(cw);
        sbe  = valid && ecc_en && res.sbe;
        dbe  = valid && ecc_en && res.dbe;
    end
endmodule

// File: rtl/ecc_fifo_errsts.sv
// Module ecc_fifo_errsts
// Sticky per-port, per-severity error flags with write-one-to-clear.
// Assumes a set in the same cycle as a clear wins.
module ecc_fifo_errsts #(
    parameter int NPORT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPORT-1:0]   sbe,
    input  logic [NPORT-1:0]   dbe,
    input  logic [2*NPORT-1:0] clr,
    output logic [2*NPORT-1:0] flags
);
    logic [2*NPORT-1:0] set_v;

    // Interleave severities per port: {dbe, sbe} for each port.
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            set_v[2*i]   = sbe[i];
            set_v[2*i+1] = dbe[i];
        end
    end

    // Hold flags, drop cleared bits, then apply new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr) | set_v;
    end
endmodule

// File: rtl/ecc_fifo.sv
// Module ecc_fifo (top)
// ECC-protected FIFO with an address window for direct initialisation and reads.
// Assumes storage is zeroed through the window before ecc_en is raised.
module ecc_fifo
    import ecc_fifo_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int WIN_BASE = 'h200,
    parameter int ADDR_W   = $clog2(DEPTH),
    parameter int LVL_W    = ADDR_W + 1,
    parameter int WA_W     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    output logic              full,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              pop_valid,
    output logic              empty,
    output logic [LVL_W-1:0]  level,
    output logic              ovf,
    output logic              udf,
    input  logic              ptr_clr,
    input  logic              win_we,
    input  logic              win_re,
    input  logic [WA_W-1:0]   win_addr,
    input  logic [DATA_W-1:0] win_wdata,
    output logic [DATA_W-1:0] win_rdata,
    output logic              win_rvalid,
    input  logic              ecc_en,
    input  logic [3:0]        err_clr,
    output logic [3:0]        err_flags,
    input  logic [CW_W-1:0]   inj_flip
);
    localparam int NPORT = 2;

    logic              do_push, do_pop, in_win, win_wr_ok, we;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr, win_loc, waddr;
    logic [CW_W-1:0]   wcw;
    logic [CW_W-1:0]   rcw   [NPORT];
    logic [NPORT-1:0]  rvld, sbe, dbe;
    logic [DATA_W-1:0] rdat  [NPORT];

    // Decode the window address into a storage location.
    always_comb begin
        in_win    = (32'(win_addr) >= WIN_BASE) && (32'(win_addr) < WIN_BASE + DEPTH);
        win_loc   = ADDR_W'(win_addr - WA_W'(WIN_BASE));
        win_wr_ok = win_we && in_win;
    end

    // Select the write source (push first) and encode with optional fault mask.
    always_comb begin
        we    = do_push || win_wr_ok;
        waddr = do_push ? wr_ptr : win_loc;
        wcw   = secded_enc(do_push ? push_data : win_wdata) ^ inj_flip;
    end

    ecc_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .clr(ptr_clr),
        .do_push(do_push), .do_pop(do_pop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .level(level), .full(full), .empty(empty), .ovf(ovf), .udf(udf)
    );

    ecc_fifo_ram #(.DEPTH(DEPTH), .WIDTH(CW_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wcw),
        .re_a(do_pop), .raddr_a(rd_ptr), .re_b(win_re && in_win), .raddr_b(win_loc),
        .rdata_a(rcw[0]), .rdata_b(rcw[1]), .rvalid_a(rvld[0]), .rvalid_b(rvld[1])
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_dec
        ecc_fifo_dec u_dec (
            .valid(rvld[g]), .ecc_en(ecc_en), .cw(rcw[g]),
            .data(rdat[g]), .sbe(sbe[g]), .dbe(dbe[g])
        );
    end

    ecc_fifo_errsts #(.NPORT(NPORT)) u_sts (
        .clk(clk), .rst_n(rst_n), .sbe(sbe), .dbe(dbe),
        .clr(err_clr), .flags(err_flags)
    );

    assign pop_data   = rdat[0];
    assign pop_valid  = rvld[0];
    assign win_rdata  = rdat[1];
    assign win_rvalid = rvld[1];
endmodule

// File: rtl/ecc_fifo_sva.sv
// Module ecc_fifo_sva
// Port-level properties of ecc_fifo, bound to every instance.
module ecc_fifo_sva #(
    parameter int DEPTH = 1024,
    parameter int LVL_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push,
    input logic             pop,
    input logic             full,
    input logic             empty,
    input logic [LVL_W-1:0] level,
    input logic             ovf,
    input logic             udf,
    input logic             ptr_clr,
    input logic             pop_valid,
    input logic             ecc_en,
    input logic [3:0]       err_clr,
    input logic [3:0]       err_flags
);
    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(level) <= DEPTH);
    p_ovf_on_full_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !ptr_clr) |=> ovf);
    p_udf_on_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !ptr_clr) |=> (udf && !pop_valid));
    p_clr_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (level == '0 && empty && !ovf && !udf));
    p_pop_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !ptr_clr) |=> pop_valid);
    p_push_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop && !ptr_clr) |=> level == $past(level) + LVL_W'(1));
    p_bypass_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ecc_en && err_clr == 4'b0) |=> $stable(err_flags));
    p_w1c_only_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr == 4'hF && !ecc_en) |=> err_flags == 4'b0);
endmodule

bind ecc_fifo ecc_fifo_sva #(.DEPTH(DEPTH)) u_sva (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .full(full), .empty(empty),
    .level(level), .ovf(ovf), .udf(udf), .ptr_clr(ptr_clr), .pop_valid(pop_valid),
    .ecc_en(ecc_en), .err_clr(err_clr), .err_flags(err_flags)
);

// File: tb/ecc_fifo_tb.sv
`timescale 1ns/1ps
module ecc_fifo_tb;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 0, pop = 0, ptr_clr = 0, win_we = 0, win_re = 0, ecc_en = 0;
    logic [31:0] push_data = '0, win_wdata = '0;
    logic [10:0] win_addr = '0;
    logic [3:0]  err_clr = '0;
    logic [38:0] inj_flip = '0;
    logic        full, empty, pop_valid, ovf, udf, win_rvalid;
    logic [31:0] pop_data, win_rdata;
    logic [10:0] level;
    logic [3:0]  err_flags;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    ecc_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .full(full),
        .pop(pop), .pop_data(pop_data), .pop_valid(pop_valid), .empty(empty),
        .level(level), .ovf(ovf), .udf(udf), .ptr_clr(ptr_clr), .win_we(win_we),
        .win_re(win_re), .win_addr(win_addr), .win_wdata(win_wdata),
        .win_rdata(win_rdata), .win_rvalid(win_rvalid), .ecc_en(ecc_en),
        .err_clr(err_clr), .err_flags(err_flags), .inj_flip(inj_flip)
    );

    always #2.5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'h9E37_0000 ^ (32'(i) * 32'd2654435761);
    endfunction

    task automatic idle();
        push = 0; pop = 0; ptr_clr = 0; win_we = 0; win_re = 0;
        err_clr = '0; inj_flip = '0;
    endtask

    task automatic win_write(input logic [10:0] a, input logic [31:0] d, input logic [38:0] f);
        win_we = 1; win_addr = a; win_wdata = d; inj_flip = f;
        tick();
        idle();
    endtask

    task automatic win_read_chk(input string req, input logic [10:0] a, input logic [31:0] exp);
        win_re = 1; win_addr = a;
        tick();
        idle();
        chk({req, " win_rvalid"}, 64'(win_rvalid), 64'(1));
        chk({req, " win_rdata"}, 64'(win_rdata), 64'(exp));
    endtask

    task automatic push_one(input logic [31:0] d, input logic [38:0] f);
        push = 1; push_data = d; inj_flip = f;
        tick();
        idle();
    endtask

    task automatic pop_chk(input string req, input logic [31:0] exp);
        pop = 1;
        tick();
        idle();
        chk({req, " pop_valid"}, 64'(pop_valid), 64'(1));
        chk({req, " pop_data"}, 64'(pop_data), 64'(exp));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #750000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] mq [DEPTH];
        int head, tail, mcnt;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) tick();
        rst_n = 1;
        chk("R1 level", 64'(level), 64'(0));
        chk("R1 empty/full", 64'({empty, full}), 64'(2'b10));
        chk("R1 valids", 64'({pop_valid, win_rvalid}), 64'(0));
        chk("R1 ovf/udf", 64'({ovf, udf}), 64'(0));
        chk("R1 err_flags", 64'(err_flags), 64'(0));

        // Zero every location through the window, clear flags, reset pointers, enable.
        for (int i = 0; i < DEPTH; i++) win_write(11'(32'h200 + i), 32'h0, '0);
        err_clr = 4'hF; ptr_clr = 1;
        tick();
        idle();
        ecc_en = 1;

        // R5: window mapping and range
        win_write(11'h200, 32'h1234_5678, '0);
        win_write(11'h1FF, 32'hDEAD_BEEF, '0);
        win_write(11'h600, 32'hCAFE_F00D, '0);
        win_read_chk("R5 base", 11'h200, 32'h1234_5678);
        win_read_chk("R5 top", 11'h5FF, 32'h0);
        win_re = 1; win_addr = 11'h600;
        tick();
        idle();
        chk("R5 out-of-range read", 64'(win_rvalid), 64'(0));
        // push wins over a simultaneous window write to location 1
        push = 1; push_data = 32'hAAAA_0001; win_we = 1; win_addr = 11'h201; win_wdata = 32'h5555_0001;
        tick();
        idle();
        win_read_chk("R5 push priority", 11'h201, 32'h0);
        pop_chk("R5 pushed word", 32'hAAAA_0001);

        // R2/R3: fill to full, overflow, drain in order
        ptr_clr = 1; tick(); idle();
        for (int i = 0; i < DEPTH; i++) push_one(pat(i), '0);
        chk("R3 full", 64'({full, level}), 64'({1'b1, 11'd1024}));
        push_one(32'hFFFF_FFFF, '0);
        chk("R3 ovf", 64'({ovf, level}), 64'({1'b1, 11'd1024}));
        for (int i = 0; i < DEPTH; i++) pop_chk("R2 order", pat(i));
        chk("R2 drained", 64'({empty, level}), 64'({1'b1, 11'd0}));

        // R4: pop while empty
        pop = 1; tick(); idle();
        chk("R4 udf/no valid", 64'({udf, pop_valid}), 64'(2'b10));

        // R6: ptr_clr keeps storage
        for (int i = 0; i < 4; i++) push_one(32'h6600_0000 + 32'(i), '0);
        ptr_clr = 1; tick(); idle();
        chk("R6 cleared", 64'({level, empty, ovf, udf}), 64'({11'd0, 1'b1, 1'b0, 1'b0}));
        win_read_chk("R6 data kept", 11'h200, 32'h6600_0000);

        // R7/R8: bypass returns raw bits, flags untouched
        ecc_en = 0;
        push_one(32'h0F0F_0F00, 39'h8);
        pop_chk("R8 raw bit flip on d0", 32'h0F0F_0F01);
        tick();
        chk("R8 flags unchanged", 64'(err_flags), 64'(0));
        ecc_en = 1;

        // R9: single error on pop path corrected, flag 0
        push_one(32'h1357_9BDF, 39'h8);
        pop_chk("R9 corrected pop", 32'h1357_9BDF);
        tick();
        chk("R9 pop single flag", 64'(err_flags), 64'(4'b0001));
        err_clr = 4'b0001; tick(); idle();
        chk("R11 clear", 64'(err_flags), 64'(0));

        // R10: double error on pop path, raw data, flag 1
        push_one(32'h2468_ACE0, 39'h28);
        pop_chk("R10 raw pop", 32'h2468_ACE3);
        tick();
        chk("R10 pop double flag", 64'(err_flags), 64'(4'b0010));

        // R9/R10/R7 on window path; parity-only flip counts as single
        win_write(11'h205, 32'h7777_0000, 39'h40);
        win_read_chk("R9 corrected window", 11'h205, 32'h7777_0000);
        tick();
        chk("R9 window single flag", 64'(err_flags), 64'(4'b0110));
        win_write(11'h206, 32'h7777_0000, 39'hC0);
        win_read_chk("R10 raw window", 11'h206, 32'h7777_000C);
        tick();
        chk("R10 window double flag", 64'(err_flags), 64'(4'b1110));
        err_clr = 4'hF; tick(); idle();
        win_write(11'h207, 32'h0000_0042, 39'h1);
        win_read_chk("R7 parity bit flip", 11'h207, 32'h0000_0042);
        tick();
        chk("R7 parity flip single", 64'(err_flags), 64'(4'b0100));
        err_clr = 4'hF; tick(); idle();

        // R11: set wins over a same-cycle clear
        push_one(32'h0BAD_F00D, 39'h8);
        pop = 1; tick(); idle();
        err_clr = 4'b0001; tick(); idle();
        chk("R11 set beats clear", 64'(err_flags), 64'(4'b0001));
        err_clr = 4'hF; tick(); idle();

        // R2: constrained random push/pop against a queue model
        ptr_clr = 1; tick(); idle();
        head = 0; tail = 0; mcnt = 0;
        for (int c = 0; c < 4000; c++) begin
            bit pu, po, acc_pu, acc_po;
            logic [31:0] d;
            pu = ($urandom % 100) < 55;
            po = ($urandom % 100) < 45;
            d  = $urandom;
            acc_pu = pu && (mcnt < DEPTH);
            acc_po = po && (mcnt > 0);
            push = pu; pop = po; push_data = d;
            tick();
            idle();
            if (acc_po) begin
                chk("R2 random data", 64'({pop_valid, pop_data}), 64'({1'b1, mq[head]}));
                head = (head + 1) % DEPTH;
                mcnt--;
            end
            if (acc_pu) begin
                mq[tail] = d;
                tail = (tail + 1) % DEPTH;
                mcnt++;
            end
            if (c % 50 == 0) chk("R2 random level", 64'(level), 64'(mcnt));
        end
        tick();
        chk("R9 no false flags", 64'(err_flags), 64'(0));
        finish_run();
    end
endmodule